// File: doc/BRIEF.md
# Isochronous Transmit Context Control Register

This block is the control and status word of one isochronous transmit DMA context. Software never writes the word directly. It writes through two aliases. A write to the set alias turns on every bit that is one in the data. A write to the clear alias turns off every bit that is one in the data. A read at either alias returns the live word. Each context's pair of aliases sits 16 bytes above the previous context's pair, so one address decoder per instance picks out its own context.

The word holds four things: a run flag, a one-shot wake request, hardware-owned active and dead flags, and a cycle-match field. The cycle-match field is an enable bit plus a 15-bit value: 2 seconds bits above a 13-bit cycle count. When run is set and cycle match is armed, the context stays idle until the bus cycle timer reaches that value. The block then gives the descriptor fetcher a single-cycle start strobe. The wake request reaches the fetcher as a one-cycle pulse. When the fetcher reports an unrecoverable fault, the context is marked dead.

Top module: `iso_ctx_ctrl`

## Requirements
- R1: Word layout: bit 31 is the match enable, bits 30:16 the match value, bit 15 run, bit 12 wake, bit 11 dead, bit 10 active; all other bits read 0. A write to the set alias (BASE_ADDR + 16*CTX_IDX) ORs data bits 31:15 into the word. A write to the clear alias (set alias + 4) clears the bits that are one in the data. A read at either alias returns the word; a read at any other address returns 0.
- R2: Writes to any other address, including the neighbouring context's aliases 16 bytes away, change nothing.
- R3: A set-alias write with bit 12 drives `wake_pulse` high, and bit 12 reads 1, in exactly the next cycle only. Both then return to 0 unless the write is repeated.
- R4: With match disabled, the first clock edge that sees run stored (the second edge after the write) raises `fetch_start` for one cycle and sets active at the same time.
- R5: With match enabled, the start waits for the first edge at which timer bits 26:25 and 24:12 equal the match value. Higher seconds bits play no part. That same edge raises the strobe and clears bit 31.
- R6: Active stays set until run is cleared or a fault arrives. Software writes to bit 10 have no effect.
- R7: `dead_in` while run is set makes bit 11 read 1, clears active, and blocks any further start. Software writes to bit 11 have no effect. Only clearing run clears it.
- R8: A clear-alias write of all ones leaves the whole word at 0.
- R9: Synchronous active-high reset clears the word and both strobes.
- R10: A clear of run at the same edge at which a start would fire suppresses that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from addr |
| cyc_timer | input | 32 | Bus cycle timer (seconds from bit 25, cycle in 24:12) |
| dead_in | input | 1 | Unrecoverable fault from the fetcher |
| fetch_start | output | 1 | One-cycle start strobe to the fetcher |
| wake_pulse | output | 1 | One-cycle wake request to the fetcher |

## Verification
A write lands in the word at the edge that samples it, and the readback shows the change at once. The wake pulse is visible in the cycle after the write. With match off, a start strobe comes one edge after run is stored. With match on, it comes at the edge that samples a matching timer, and the fault flag follows at the edge that samples `dead_in`. The bench drives inputs on the falling edge, steps a behavioural model at the rising edge, and compares strobes and readback on the next falling edge. Because of this, each expectation lands in exactly the cycle the latencies above give.

// File: rtl/ctxctl_pkg.sv
package ctxctl_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SEC_W      = 2;
    localparam int unsigned CYC_W      = 13;
    localparam int unsigned MATCH_W    = SEC_W + CYC_W;
    localparam int unsigned TMR_CYC_LO = 12;
    localparam int unsigned TMR_SEC_LO = TMR_CYC_LO + CYC_W;
    localparam int unsigned B_CMEN     = 31;
    localparam int unsigned B_CMLO     = B_CMEN - MATCH_W;
    localparam int unsigned B_RUN      = 15;
    localparam int unsigned B_WAKE     = 12;
    localparam int unsigned B_DEAD     = 11;
    localparam int unsigned B_ACT      = 10;

    typedef enum logic [1:0] {ACC_NONE, ACC_SET, ACC_CLR} acc_kind_e;

    typedef struct packed {
        logic               cm_en;
        logic [MATCH_W-1:0] cm_val;
        logic               run;
        logic               wake;
        logic               dead;
        logic               active;
    } ctx_ctrl_t;

    function automatic logic [WORD_W-1:0] pack_word(input ctx_ctrl_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_CMEN]                  = s.cm_en;
        w[B_CMEN-1:B_CMLO]         = s.cm_val;
        w[B_RUN]                   = s.run;
        w[B_WAKE]                  = s.wake;
        w[B_DEAD]                  = s.dead;
        w[B_ACT]                   = s.active;
        return w;
    endfunction

    function automatic logic [MATCH_W-1:0] timer_stamp(input logic [WORD_W-1:0] t);
        return {t[TMR_SEC_LO +: SEC_W], t[TMR_CYC_LO +: CYC_W]};
    endfunction
endpackage

// File: rtl/ctx_addr_dec.sv
module ctx_addr_dec
    import ctxctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] SET_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic              rd_hit
);
    logic hit_set, hit_clr;
    assign hit_set = (addr == SET_ADDR);
    assign hit_clr = (addr == CLR_ADDR);
    assign rd_hit  = hit_set | hit_clr;

    always_comb begin
        kind = ACC_NONE;
        if (wr_en && hit_set)      kind = ACC_SET;
        else if (wr_en && hit_clr) kind = ACC_CLR;
    end
endmodule

// File: rtl/ctx_cycle_match.sv
module ctx_cycle_match
    import ctxctl_pkg::*;
(
    input  logic [WORD_W-1:0]  cyc_timer,
    input  logic [MATCH_W-1:0] cm_val,
    output logic               hit
);
    logic [MATCH_W-1:0] stamp;
    assign stamp = timer_stamp(cyc_timer);
    assign hit   = (stamp == cm_val);
endmodule

// File: rtl/ctx_ctrl_regs.sv
module ctx_ctrl_regs
    import ctxctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         kind,
    input  logic [WORD_W-1:0] wdata,
    input  logic              dead_in,
    input  logic              stamp_hit,
    output ctx_ctrl_t         st,
    output logic              fetch_start
);
    ctx_ctrl_t nxt;
    logic      start_q;
    logic      set_w, clr_w, clr_run, fault, go;

    always_comb begin
        set_w   = (kind == ACC_SET);
        clr_w   = (kind == ACC_CLR);
        clr_run = clr_w & wdata[B_RUN];
        fault   = dead_in & st.run;
        go      = st.run & ~st.active & ~st.dead & (~st.cm_en | stamp_hit)
                  & ~clr_run & ~fault;

        nxt = st;
        if (set_w) begin
            nxt.cm_en  = st.cm_en  | wdata[B_CMEN];
            nxt.cm_val = st.cm_val | wdata[B_CMEN-1:B_CMLO];
            nxt.run    = st.run    | wdata[B_RUN];
        end else if (clr_w) begin
            nxt.cm_en  = st.cm_en  & ~wdata[B_CMEN];
            nxt.cm_val = st.cm_val & ~wdata[B_CMEN-1:B_CMLO];
            nxt.run    = st.run    & ~wdata[B_RUN];
        end
        nxt.wake = set_w & wdata[B_WAKE];

        if (clr_run) begin
            nxt.dead   = 1'b0;
            nxt.active = 1'b0;
        end else if (fault) begin
            nxt.dead   = 1'b1;
            nxt.active = 1'b0;
        end else if (go) begin
            nxt.active = 1'b1;
        end
        if (go) nxt.cm_en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            start_q <= 1'b0;
        end else begin
            st      <= nxt;
            start_q <= go;
        end
    end

    assign fetch_start = start_q;
endmodule

// File: rtl/iso_ctx_ctrl.sv
module iso_ctx_ctrl
    import ctxctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BASE_ADDR  = 'h200,
    parameter int unsigned CTX_IDX    = 0,
    parameter int unsigned STRIDE     = 16,
    parameter int unsigned CLR_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    input  logic [31:0]       cyc_timer,
    input  logic              dead_in,
    output logic              fetch_start,
    output logic              wake_pulse
);
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(BASE_ADDR + STRIDE * CTX_IDX);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(BASE_ADDR + STRIDE * CTX_IDX + CLR_OFFSET);

    acc_kind_e         kind;
    logic              rd_hit;
    logic              stamp_hit;
    ctx_ctrl_t         st;
    logic [WORD_W-1:0] ctl_word;

    ctx_addr_dec #(.ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .kind  (kind),
        .rd_hit(rd_hit)
    );

    ctx_cycle_match u_match (
        .cyc_timer(cyc_timer),
        .cm_val   (st.cm_val),
        .hit      (stamp_hit)
    );

    ctx_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .wdata      (wdata),
        .dead_in    (dead_in),
        .stamp_hit  (stamp_hit),
        .st         (st),
        .fetch_start(fetch_start)
    );

    assign ctl_word   = pack_word(st);
    assign rd_data    = rd_hit ? ctl_word : '0;
    assign wake_pulse = st.wake;
endmodule

// File: rtl/iso_ctx_ctrl_chk.sv
module iso_ctx_ctrl_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] SET_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              dead_in,
    input logic              fetch_start,
    input logic              wake_pulse,
    input logic [31:0]       ctl_word
);
    logic wake_wr, run_clr;
    assign wake_wr = wr_en && (addr == SET_ADDR) && wdata[12];
    assign run_clr = wr_en && (addr == CLR_ADDR) && wdata[15];

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (ctl_word == 32'd0 && !fetch_start && !wake_pulse));
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        fetch_start |=> !fetch_start);
    a_r3_wake_follows: assert property (@(posedge clk) disable iff (rst)
        wake_wr |=> wake_pulse);
    a_r3_wake_self_clears: assert property (@(posedge clk) disable iff (rst)
        (wake_pulse && !wake_wr) |=> !wake_pulse);
    a_r5_start_needs_run: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> $past(ctl_word[15]));
    a_r5_match_disarmed: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> !ctl_word[31]);
    a_r6_active_on_start: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> ctl_word[10]);
    a_r6_active_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[10] && !dead_in && !run_clr) |=> ctl_word[10]);
    a_r7_dead_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[11] && !run_clr) |=> ctl_word[11]);
    a_r7_dead_not_active: assert property (@(posedge clk) disable iff (rst)
        ctl_word[11] |-> !ctl_word[10]);
endmodule

bind iso_ctx_ctrl iso_ctx_ctrl_chk #(
    .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dead_in(dead_in), .fetch_start(fetch_start), .wake_pulse(wake_pulse),
    .ctl_word(ctl_word)
);

// File: tb/tb_iso_ctx_ctrl.sv
`timescale 1ns/1ps
module tb_iso_ctx_ctrl;
    localparam logic [11:0] SET = 12'h220;
    localparam logic [11:0] CLR = 12'h224;
    localparam logic [11:0] NSET = 12'h210;
    localparam logic [11:0] NCLR = 12'h214;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [11:0] addr = SET;
    logic [31:0] wdata = '0;
    logic [31:0] cyc_timer = '0;
    logic dead_in = 1'b0;
    logic [31:0] rd_data;
    logic fetch_start, wake_pulse;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit m_cmen, m_run, m_wake, m_dead, m_act, m_start;
    bit [14:0] m_val;

    always #2.5 clk = ~clk;

    iso_ctx_ctrl #(.ADDR_W(12), .BASE_ADDR('h200), .CTX_IDX(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .cyc_timer(cyc_timer), .dead_in(dead_in),
        .fetch_start(fetch_start), .wake_pulse(wake_pulse)
    );

    function automatic logic [31:0] tmr(input int sec, input int cyc);
        return (32'(sec) << 25) | (32'(cyc) << 12);
    endfunction

    function automatic logic [31:0] model_word();
        return {m_cmen, m_val, m_run, 2'b00, m_wake, m_dead, m_act, 10'd0};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_step();
        bit is_set, is_clr, kill, fault, go, stamp;
        if (rst) begin
            {m_cmen, m_run, m_wake, m_dead, m_act, m_start} = '0;
            m_val = '0;
            return;
        end
        is_set = wr_en && addr == SET;
        is_clr = wr_en && addr == CLR;
        kill   = is_clr && wdata[15];
        fault  = dead_in && m_run;
        stamp  = (cyc_timer[26:25] == m_val[14:13]) && (cyc_timer[24:12] == m_val[12:0]);
        go     = m_run && !m_act && !m_dead && (!m_cmen || stamp) && !kill && !fault;
        m_start = go;
        m_wake  = is_set && wdata[12];
        if (kill) begin m_dead = 0; m_act = 0; end
        else if (fault) begin m_dead = 1; m_act = 0; end
        else if (go) m_act = 1;
        if (is_set) begin
            m_run  = m_run  | wdata[15];
            m_cmen = m_cmen | wdata[31];
            m_val  = m_val  | wdata[30:16];
        end else if (is_clr) begin
            m_run  = m_run  & ~wdata[15];
            m_cmen = m_cmen & ~wdata[31];
            m_val  = m_val  & ~wdata[30:16];
        end
        if (go) m_cmen = 0;
    endtask

    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic dd, input logic [31:0] tm);
        wr_en = we; addr = a; wdata = d; dead_in = dd; cyc_timer = tm;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R4 start strobe", 32'(fetch_start), 32'(m_start));
        chk("R3 wake pulse", 32'(wake_pulse), 32'(m_wake));
        chk("R1 readback", rd_data, (addr == SET || addr == CLR) ? model_word() : 32'd0);
    endtask

    task automatic idle(input int n, input logic [31:0] tm);
        for (int i = 0; i < n; i++) cyc(1'b0, SET, 32'd0, 1'b0, tm);
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] v);
        wr_en = 1'b0; addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1;
        idle(3, 32'd0);
        rst = 1'b0;
        peek(SET, v); chk("R9 reset word", v, 32'd0);
        chk("R9 reset strobes", {fetch_start, wake_pulse}, 2'b00);

        // R1 set/clear aliases
        cyc(1'b1, SET, 32'h0001_0000, 1'b0, 32'd0);
        peek(CLR, v); chk("R1 read clear alias", v, 32'h0001_0000);
        peek(12'h228, v); chk("R1 foreign read", v, 32'd0);
        cyc(1'b1, CLR, 32'h0001_0000, 1'b0, 32'd0);
        peek(SET, v); chk("R1 clear bits", v, 32'd0);

        // R2 neighbour writes ignored
        cyc(1'b1, NSET, 32'h8001_9000, 1'b0, 32'd0);
        chk("R2 no wake", 32'(wake_pulse), 32'd0);
        peek(SET, v); chk("R2 neighbour set", v, 32'd0);
        idle(2, 32'd0);
        chk("R2 no start", 32'(fetch_start), 32'd0);

        // R3 wake
        cyc(1'b1, SET, 32'h0000_1000, 1'b0, 32'd0);
        chk("R3 wake high", 32'(wake_pulse), 32'd1);
        peek(SET, v); chk("R3 bit12 read", v, 32'h0000_1000);
        idle(1, 32'd0);
        chk("R3 wake cleared", 32'(wake_pulse), 32'd0);

        // R4 immediate start, R6 active
        cyc(1'b1, SET, 32'h0000_8000, 1'b0, 32'd0);
        chk("R4 no start yet", 32'(fetch_start), 32'd0);
        idle(1, 32'd0);
        chk("R4 start", 32'(fetch_start), 32'd1);
        peek(SET, v); chk("R6 active set", v, 32'h0000_8400);
        cyc(1'b1, CLR, 32'h0000_0400, 1'b0, 32'd0);
        peek(SET, v); chk("R6 active write ignored", v, 32'h0000_8400);
        cyc(1'b1, SET, 32'h0000_0800, 1'b0, 32'd0);
        peek(SET, v); chk("R7 dead write ignored", v, 32'h0000_8400);

        // R7 fault
        cyc(1'b0, SET, 32'd0, 1'b1, 32'd0);
        peek(SET, v); chk("R7 dead set", v, 32'h0000_8800);
        idle(3, 32'd0);
        chk("R7 no restart", 32'(fetch_start), 32'd0);
        cyc(1'b1, CLR, 32'h0000_0800, 1'b0, 32'd0);
        peek(SET, v); chk("R7 dead sticky", v, 32'h0000_8800);
        cyc(1'b1, CLR, 32'h0000_8000, 1'b0, 32'd0);
        peek(SET, v); chk("R7 cleared with run", v, 32'd0);

        // R5 cycle match, value seconds=1 cycle=7999
        cyc(1'b1, SET, 32'hBF3F_0000, 1'b0, tmr(0, 0));
        cyc(1'b1, SET, 32'h0000_8000, 1'b0, tmr(0, 0));
        idle(3, tmr(2, 7999));
        chk("R5 wrong seconds", 32'(fetch_start), 32'd0);
        idle(1, tmr(1, 7998));
        chk("R5 wrong cycle", 32'(fetch_start), 32'd0);
        idle(1, tmr(5, 7999));
        chk("R5 start on match", 32'(fetch_start), 32'd1);
        peek(SET, v); chk("R5 enable cleared", v, 32'h3F3F_8400);
        idle(2, tmr(5, 7999));

        // R8 clear all
        cyc(1'b1, CLR, 32'hFFFF_FFFF, 1'b0, 32'd0);
        peek(SET, v); chk("R8 all cleared", v, 32'd0);

        // R10 clear of run races start
        cyc(1'b1, SET, 32'hBF3F_0000, 1'b0, 32'd0);
        cyc(1'b1, SET, 32'h0000_8000, 1'b0, 32'd0);
        cyc(1'b1, CLR, 32'h0000_8000, 1'b0, tmr(1, 7999));
        chk("R10 suppressed", 32'(fetch_start), 32'd0);
        idle(1, tmr(1, 7999));
        chk("R10 none later", 32'(fetch_start), 32'd0);
        peek(SET, v); chk("R10 word", v, 32'hBF3F_0000);

        // R9 reset mid-operation
        cyc(1'b1, CLR, 32'h8000_0000, 1'b0, 32'd0);
        cyc(1'b1, SET, 32'h0000_9000, 1'b0, 32'd0);
        rst = 1'b1;
        idle(1, 32'd0);
        rst = 1'b0;
        peek(SET, v); chk("R9 mid reset", v, 32'd0);
        chk("R9 strobes low", {fetch_start, wake_pulse}, 2'b00);
        idle(2, 32'd0);

        finish_run();
    end
endmodule